// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

The block derives two phase clocks from one slow reference clock, entirely in a faster system-clock domain. The first phase (`phi1_o`) is active during the low half of the reference and the second phase (`phi2_o`) during the high half. The two are never high together. After one phase falls, the other may rise only once a dead gap has passed. The gap is set by a 4-bit count of system cycles.

The reference is first brought into the system domain through a two-flop synchronizer, and all decisions use the synchronized level. A phase may rise only while the other phase's registered output is seen low. A phase drops in the first cycle after its synchronized half ends. If the dead gap would use up a whole half period, that half's phase is left out for the period. It is never squeezed against the other phase. After reset both phases stay low until the synchronized reference has shown two rising edges, which is one full reference period.

Top module: `ncg_clkgen`

## Requirements
- R1: While `rst_n` is low, both `phi1_o` and `phi2_o` are low.
- R2: `phi1_o` is high only while the synchronized reference (two system flops behind `ref_clk_i`) is low.
- R3: `phi2_o` is high only while the synchronized reference is high.
- R4: `phi1_o` and `phi2_o` are never high in the same system cycle.
- R5: Between any fall of one phase and the next rise of either phase, both are low for at least `dead_cfg_i` + 1 cycles. A setting of 0 still gives one such cycle.
- R6: A phase rises when the synchronized reference has held its half for `dead_cfg_i` + 2 consecutive system-clock samples. The first sample is the one that shows the new level.
- R7: A high phase falls in the first system cycle after the synchronized reference leaves its half.
- R8: After reset is released, both phases stay low until the second synchronized rising edge of the reference has been seen.
- R9: If a half period is too short to satisfy R6, that half's phase stays low for the whole half, and the other phase is not extended into it.
- R10: The dead-time setting is 4 bits wide (0 to 15) and is captured each time a gap begins. It is intended to change only while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| dead_cfg_i | input | 4 | Dead time in system cycles, minus one |
| phi1_o | output | 1 | Phase active in the reference low half |
| phi2_o | output | 1 | Phase active in the reference high half |

## Verification
A wrong internal state here shows at the ports within one system cycle. Some faults raise a phase in the wrong half or let it overlap the other. Some load a stale dead count, which shifts a rising edge by one or more cycles against the run-length rule. Others mistrack the startup edge count, which raises a phase during the first reference period. The bench predicts each phase on every cycle from the run length of the synchronized reference level, so any such deviation is flagged on the very cycle it appears.

// File: rtl/ncg_pkg.sv
package ncg_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_A = 2'd0,
    ST_WAIT_B = 2'd1,
    ST_GAP    = 2'd2,
    ST_RUN    = 2'd3
  } ncg_state_e;
endpackage

// File: rtl/ncg_ref_sync.sv
module ncg_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic lvl_o,
  output logic rise_o
);
  // pipe[0..STAGES-1] is the synchronizer, pipe[STAGES] remembers the last level
  logic [STAGES:0] pipe;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= ref_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= 1'b0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign lvl_o  = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/ncg_phase_ctrl.sv
module ncg_phase_ctrl
  import ncg_pkg::*;
#(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic              rise_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              p1_o,
  output logic              p2_o
);
  localparam int RUN_W = DEAD_W + 1;

  ncg_state_e        st_q;
  logic              side_q;
  logic [DEAD_W-1:0] cnt_q;
  logic [DEAD_W-1:0] gap_len_q;
  logic              p1_q, p2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_WAIT_A;
      side_q    <= 1'b0;
      cnt_q     <= '0;
      gap_len_q <= '0;
      p1_q      <= 1'b0;
      p2_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_WAIT_A: if (rise_i) st_q <= ST_WAIT_B;
        ST_WAIT_B: if (rise_i) begin
          st_q      <= ST_GAP;
          side_q    <= 1'b1;
          cnt_q     <= dead_i;
          gap_len_q <= dead_i;
        end
        ST_GAP: begin
          if (lvl_i != side_q) begin
            side_q    <= lvl_i;
            cnt_q     <= dead_i;
            gap_len_q <= dead_i;
          end else if (cnt_q == '0) begin
            // interlock: rise only while the other phase is fed back low
            if (!side_q && !p2_q) begin
              p1_q <= 1'b1;
              st_q <= ST_RUN;
            end else if (side_q && !p1_q) begin
              p2_q <= 1'b1;
              st_q <= ST_RUN;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (lvl_i != side_q) begin
            p1_q      <= 1'b0;
            p2_q      <= 1'b0;
            side_q    <= lvl_i;
            cnt_q     <= dead_i;
            gap_len_q <= dead_i;
            st_q      <= ST_GAP;
          end
        end
      endcase
    end
  end

  assign p1_o = p1_q;
  assign p2_o = p2_q;

  // run of consecutive cycles with both phases low, saturating
  logic [RUN_W-1:0] lowrun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lowrun_q <= '0;
    else if (p1_q || p2_q)       lowrun_q <= '0;
    else if (lowrun_q != '1)     lowrun_q <= lowrun_q + 1'b1;
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_q && p2_q));
  // R2
  phi1_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p1_q |-> $past(!lvl_i));
  // R3
  phi2_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p2_q |-> $past(lvl_i));
  // R7
  phi1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_q && lvl_i) |=> !p1_q);
  // R7
  phi2_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_q && !lvl_i) |=> !p2_q);
  // R5
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(p1_q) || $rose(p2_q)) |-> ($past(lowrun_q) >= {1'b0, gap_len_q}));
endmodule

// File: rtl/ncg_clkgen.sv
module ncg_clkgen #(
  parameter int DEAD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_i,
  input  logic [DEAD_W-1:0] dead_cfg_i,
  output logic              phi1_o,
  output logic              phi2_o
);
  logic ref_lvl;
  logic ref_rise;

  ncg_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_i  (ref_clk_i),
    .lvl_o  (ref_lvl),
    .rise_o (ref_rise)
  );

  ncg_phase_ctrl #(.DEAD_W(DEAD_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ref_lvl),
    .rise_i (ref_rise),
    .dead_i (dead_cfg_i),
    .p1_o   (phi1_o),
    .p2_o   (phi2_o)
  );
endmodule

// File: tb/ncg_clkgen_tb.sv
module ncg_clkgen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic [3:0] dead_cfg = 4'd0;
  logic       phi1, phi2;

  ncg_clkgen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_clk_i  (ref_clk),
    .dead_cfg_i (dead_cfg),
    .phi1_o     (phi1),
    .phi2_o     (phi2)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // behavioural reference: synchronizer delay plus run-length rule
  int m_s1, m_s2, m_s3, m_rises, m_run;
  bit exp1, exp2;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rises = 0; m_run = 0;
      exp1 = 0; exp2 = 0;
    end else begin
      if (m_s2 != m_s3) m_run = 1;
      else if (m_run < 1000) m_run++;
      if (m_s2 == 1 && m_s3 == 0) m_rises++;
      exp1 = (m_rises >= 2) && (m_s2 == 0) && (m_run >= dead_cfg + 2);
      exp2 = (m_rises >= 2) && (m_s2 == 1) && (m_run >= dead_cfg + 2);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_clk;
    end
  end

  int  lowrun = 0;
  bit  prev1 = 0, prev2 = 0;
  bit  compare_on = 0;
  int  phi2_hi_cnt = 0;
  int  any_hi_cnt = 0;
  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      checks++;
      if (phi1 !== exp1) begin
        fails++;
        $display("FAIL R6 R7 R8 phi1 cycle %0d: actual %b expected %b", cycles, phi1, exp1);
      end
      checks++;
      if (phi2 !== exp2) begin
        fails++;
        $display("FAIL R6 R7 R8 phi2 cycle %0d: actual %b expected %b", cycles, phi2, exp2);
      end
      checks++;
      if (phi1 && phi2) begin
        fails++;
        $display("FAIL R4 overlap cycle %0d: actual 11 expected not both high", cycles);
      end
      if ((phi1 && !prev1 || phi2 && !prev2)) begin
        checks++;
        if (lowrun < dead_cfg + 1) begin
          fails++;
          $display("FAIL R5 gap: actual %0d expected >= %0d", lowrun, dead_cfg + 1);
        end
      end
      if (!phi1 && !phi2) lowrun++; else lowrun = 0;
      if (phi2) phi2_hi_cnt++;
      if (phi1 || phi2) any_hi_cnt++;
      prev1 = phi1; prev2 = phi2;
    end
  end

  task automatic do_reset(input int cfg);
    compare_on = 0;
    @(negedge clk);
    rst_n = 1'b0; ref_clk = 1'b0; dead_cfg = cfg[3:0];
    repeat (4) @(negedge clk);
    checks++;  // R1
    if (phi1 !== 1'b0 || phi2 !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %b%b expected 00", phi1, phi2);
    end
    rst_n = 1'b1; lowrun = 0; prev1 = 0; prev2 = 0;
    compare_on = 1;
  endtask

  task automatic run_ref(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b1; repeat (hi) @(negedge clk);
      ref_clk = 1'b0; repeat (lo) @(negedge clk);
    end
  endtask

  initial begin
    // R1 R8 R6 R10: dead time 3, even halves; no phase during first period
    do_reset(3);
    any_hi_cnt = 0;
    run_ref(20, 20, 1);
    checks++;  // R8
    if (any_hi_cnt != 0) begin
      fails++;
      $display("FAIL R8 startup: actual %0d high cycles expected 0", any_hi_cnt);
    end
    run_ref(20, 20, 4);
    // R5: zero setting still leaves one low cycle
    do_reset(0);
    run_ref(6, 6, 8);
    // largest setting with long halves
    do_reset(15);
    run_ref(30, 30, 4);
    // R9: high half too short for dead time 15, so phi2 never rises
    do_reset(15);
    run_ref(8, 40, 2);
    phi2_hi_cnt = 0;
    any_hi_cnt = 0;
    run_ref(8, 40, 3);
    checks++;  // R9
    if (phi2_hi_cnt != 0) begin
      fails++;
      $display("FAIL R9 skip: actual %0d phi2 cycles expected 0", phi2_hi_cnt);
    end
    checks++;  // R9 other phase still runs
    if (any_hi_cnt == 0) begin
      fails++;
      $display("FAIL R9 phi1 present: actual 0 expected >0");
    end
    // R2 R3: asymmetric halves with a short gap
    do_reset(2);
    run_ref(5, 12, 6);
    run_ref(3, 3, 4);
    repeat (10) @(negedge clk);
    done = 1;
  end

  initial begin
    wait (done || cycles > 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule